// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose pin controller. Its pins are grouped into banks of sixteen. Each bank decodes its own 128-byte register window, and all of its registers carry the bank's pins in bits 15:0. Software uses per-pin bits to choose direction, output value, input enable and an access mask that gates reads and writes of the pin data. The pads are reached through separate input, output and output-enable vectors.

Every pin has an interrupt detector. Its sense comes from three bits:
- a level/edge select;
- an any-edge override;
- a polarity bit.

Pin inputs pass through a two-flop synchronizer before detection. Edge events are latched until software acknowledges them by writing one to the clear register. Level status follows the synchronized pin directly. Each bank's latched or level status, ANDed with its enable bits, is ORed over all banks into one interrupt line.

The register bus is a simple 32-bit write strobe with a combinational read. A read returns data in the same cycle the address is presented.

Top module: `pinbank_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `pad_oe` and `pad_out` are all zero and `irq` is low.
- R2: Bank n decodes byte addresses n*0x80 to n*0x80+0x7F. Word offsets are 0x00 data, 0x04 data mask, 0x08 direction, 0x0C level select, 0x10 any-edge, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status, 0x20 masked status, 0x24 clear and 0x28 input enable. Bits 31:16 always read zero, and the clear register always reads zero.
- R3: A direction bit of 1 drives `pad_oe` high for that pin, and `pad_out` then equals the data bit. A direction bit of 0 leaves `pad_oe` and `pad_out` low.
- R4: A data write changes only the pins whose data-mask bit is 1. A data read returns 0 for every pin whose data-mask bit is 0.
- R5: For an unmasked pin with direction 0, a data read returns the pin input two clocks after it changes when input enable is 1. It returns 0 when input enable is 0. A disabled input is also seen as 0 by the detector.
- R6: With level select 0 and any-edge 0, polarity 1 latches a raw status bit on a rising input and polarity 0 latches it on a falling input. The opposite edge sets nothing.
- R7: With level select 0 and any-edge 1, both rising and falling inputs latch the raw status bit.
- R8: With level select 1, raw status equals the synchronized input when polarity is 1 and its inverse when polarity is 0. The bit is not latched, and a clear write leaves it unchanged.
- R9: Masked status is raw status ANDed with interrupt enable. `irq` is high exactly when any masked status bit in any bank is 1.
- R10: Writing 1 to a clear bit resets the latched edge status of that pin. A latched bit falls only through such a write. If an edge arrives in the same cycle as the clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (11) | Byte address; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data; bits 15:0 used |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | NUM_PINS (256) | Pin input levels, asynchronous |
| pad_out | output | NUM_PINS (256) | Pin output values |
| pad_oe | output | NUM_PINS (256) | Pin output enables |
| irq | output | 1 | OR of all masked status bits |

## Verification
The assertions assume that reset is held for at least two clocks before the first checked cycle, so the histories they compare start from reset values. They also assume that `bus_wr` is a clean single-cycle strobe with a stable address. The bench meets both conditions: it holds reset for three cycles and drives every bus and pad change on the falling clock edge, so each rising edge sees settled inputs. The bench-driven edge-and-clear collision is timed so that the clear write and the detected edge reach the same rising edge, which is the case the collision assertion is written for.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int BANK_PINS    = 16;
    localparam int BANK_SPAN_LG = 7;
    localparam int RSEL_W       = BANK_SPAN_LG - 2;

    typedef logic [BANK_PINS-1:0] pinvec_t;

    // Word index inside a bank window; the values fix the register offsets.
    typedef enum logic [RSEL_W-1:0] {
        REG_DATA  = 5'd0,
        REG_DMASK = 5'd1,
        REG_DIR   = 5'd2,
        REG_LVL   = 5'd3,
        REG_ANY   = 5'd4,
        REG_POL   = 5'd5,
        REG_IEN   = 5'd6,
        REG_RAW   = 5'd7,
        REG_MSK   = 5'd8,
        REG_CLR   = 5'd9,
        REG_INEN  = 5'd10
    } reg_sel_e;

    typedef struct packed {
        pinvec_t dout;
        pinvec_t dmask;
        pinvec_t dir;
        pinvec_t lvl_mode;
        pinvec_t any_edge;
        pinvec_t polarity;
        pinvec_t ien;
        pinvec_t inen;
    } bank_cfg_t;

    function automatic pinvec_t merge_masked(pinvec_t cur, pinvec_t nxt, pinvec_t allow);
        return (cur & ~allow) | (nxt & allow);
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect
    import pinbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t level_in,
    input  pinvec_t lvl_mode,
    input  pinvec_t any_edge,
    input  pinvec_t polarity,
    input  pinvec_t clr_vec,
    output pinvec_t raw
);
    pinvec_t prev_q;
    pinvec_t latch_q;
    pinvec_t rise;
    pinvec_t fall;
    pinvec_t edge_hit;

    assign rise = level_in & ~prev_q;
    assign fall = ~level_in & prev_q;

    always_comb begin
        edge_hit = ~lvl_mode & ( (any_edge & (rise | fall))
                               | (~any_edge & polarity & rise)
                               | (~any_edge & ~polarity & fall) );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= level_in;
            latch_q <= (latch_q & ~clr_vec) | edge_hit;
        end
    end

    assign raw = (lvl_mode & ~(level_in ^ polarity)) | (~lvl_mode & latch_q);

    // R10: a latched event disappears only where a clear bit was written
    assert_latch_only_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        (($past(latch_q) & ~latch_q & ~$past(clr_vec)) == '0));

    // R10: an edge seen in a cycle is latched on the next edge even with a clear
    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (($past(edge_hit) & ~latch_q) == '0));
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RSEL_W-1:0] rsel,
    input  pinvec_t           wdata,
    input  pinvec_t           pin_in,
    output pinvec_t           rdata,
    output pinvec_t           pin_out,
    output pinvec_t           pin_oe,
    output pinvec_t           mstat
);
    bank_cfg_t cfg_q;
    pinvec_t   sync_in;
    pinvec_t   sampled;
    pinvec_t   data_view;
    pinvec_t   clr_vec;
    pinvec_t   raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (rsel)
                REG_DATA:  cfg_q.dout     <= merge_masked(cfg_q.dout, wdata, cfg_q.dmask);
                REG_DMASK: cfg_q.dmask    <= wdata;
                REG_DIR:   cfg_q.dir      <= wdata;
                REG_LVL:   cfg_q.lvl_mode <= wdata;
                REG_ANY:   cfg_q.any_edge <= wdata;
                REG_POL:   cfg_q.polarity <= wdata;
                REG_IEN:   cfg_q.ien      <= wdata;
                REG_INEN:  cfg_q.inen     <= wdata;
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr_en && rsel == REG_CLR) ? wdata : '0;

    pinbank_sync #(.WIDTH(BANK_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    assign sampled = sync_in & cfg_q.inen;

    pinbank_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .level_in (sampled),
        .lvl_mode (cfg_q.lvl_mode),
        .any_edge (cfg_q.any_edge),
        .polarity (cfg_q.polarity),
        .clr_vec  (clr_vec),
        .raw      (raw)
    );

    assign data_view = cfg_q.dmask & ((cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & sampled));
    assign mstat     = raw & cfg_q.ien;
    assign pin_out   = cfg_q.dout & cfg_q.dir;
    assign pin_oe    = cfg_q.dir;

    always_comb begin
        case (rsel)
            REG_DATA:  rdata = data_view;
            REG_DMASK: rdata = cfg_q.dmask;
            REG_DIR:   rdata = cfg_q.dir;
            REG_LVL:   rdata = cfg_q.lvl_mode;
            REG_ANY:   rdata = cfg_q.any_edge;
            REG_POL:   rdata = cfg_q.polarity;
            REG_IEN:   rdata = cfg_q.ien;
            REG_RAW:   rdata = raw;
            REG_MSK:   rdata = mstat;
            REG_INEN:  rdata = cfg_q.inen;
            default:   rdata = '0;
        endcase
    end

    // R4: output data bits outside the access mask never change
    assert_masked_data_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (((cfg_q.dout ^ $past(cfg_q.dout)) & ~$past(cfg_q.dmask)) == '0));

    // R3: output enables move only after a direction write
    assert_oe_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && rsel == REG_DIR) |-> $stable(pin_oe));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter  int NUM_BANKS = 16,
    localparam int BANK_LG   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_LG + BANK_SPAN_LG,
    localparam int NUM_PINS  = NUM_BANKS * BANK_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    logic [BANK_LG-1:0]   bank_idx;
    logic [RSEL_W-1:0]    rsel;
    logic [NUM_BANKS-1:0] bank_hit;
    pinvec_t              bank_rd [NUM_BANKS];
    pinvec_t              bank_ms [NUM_BANKS];

    assign bank_idx = bus_addr[ADDR_W-1:BANK_SPAN_LG];
    assign rsel     = bus_addr[BANK_SPAN_LG-1:2];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = (bank_idx == BANK_LG'(b));

        pinbank_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_wr && bank_hit[b]),
            .rsel    (rsel),
            .wdata   (bus_wdata[BANK_PINS-1:0]),
            .pin_in  (pad_in[b*BANK_PINS +: BANK_PINS]),
            .rdata   (bank_rd[b]),
            .pin_out (pad_out[b*BANK_PINS +: BANK_PINS]),
            .pin_oe  (pad_oe[b*BANK_PINS +: BANK_PINS]),
            .mstat   (bank_ms[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) bus_rdata[BANK_PINS-1:0] = bank_rd[b];
        end
    end

    always_comb begin
        irq = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            irq = irq | (|bank_ms[b]);
        end
    end

    // R2: the upper half of every read is zero
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[31:BANK_PINS] == '0));
endmodule

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb;
    localparam int NB = 16;
    localparam int NP = NB * 16;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] bus_addr;
    logic          bus_wr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] sh [NB][11];

    always #4 clk = ~clk;

    pinbank_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_addr  = AW'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        bus_addr = AW'(addr);
        #1;
        data = bus_rdata;
    endtask

    function automatic int aof(input int bank, input int r);
        return bank * 128 + r * 4;
    endfunction

    function automatic logic [15:0] exp_read(input int b, input int r);
        if (r == 0) return sh[b][1] & sh[b][2] & sh[b][0];
        return sh[b][r];
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < 11; r++) sh[b][r] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung (actual=running expected=done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int regs [8] = '{0, 1, 2, 3, 4, 5, 6, 10};
        logic [31:0] d;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
        void'($urandom(32'd20240611));
        tick(1);
        do_reset();

        // R1: reset state
        for (int r = 0; r < 11; r++) begin
            rd(aof(0, r), d);  check("R1 bank0 reg", d, 32'h0);
            rd(aof(15, r), d); check("R1 bank15 reg", d, 32'h0);
        end
        check("R1 pad_oe", 32'(|pad_oe), 32'h0);
        check("R1 pad_out", 32'(|pad_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2/R3/R4: random configuration traffic with inputs held low
        for (int i = 0; i < 300; i++) begin
            int b, r;
            logic [31:0] w;
            b = $urandom_range(NB - 1);
            r = regs[$urandom_range(7)];
            w = $urandom;
            wr(aof(b, r), w);
            if (r == 0) sh[b][0] = (sh[b][0] & ~sh[b][1]) | (w[15:0] & sh[b][1]);
            else        sh[b][r] = w[15:0];
            rd(aof(b, r), d);
            check(r == 0 ? "R4 masked data read" : "R2 register readback", d, {16'h0, exp_read(b, r)});
            check("R3 pad_oe slice", {16'h0, pad_oe[b*16 +: 16]}, {16'h0, sh[b][2]});
            check("R3 pad_out slice", {16'h0, pad_out[b*16 +: 16]}, {16'h0, sh[b][0] & sh[b][2]});
        end

        do_reset();

        // R2: upper bits, window offset, clear register reads zero
        wr(aof(2, 2), 32'hFFFF_FFFF);
        rd(aof(2, 2), d); check("R2 upper bits zero", d, 32'h0000_FFFF);
        check("R3 bank2 oe", {16'h0, pad_oe[47:32]}, 32'h0000_FFFF);
        wr(aof(2, 2), 32'h0);
        wr(aof(15, 1), 32'h0000_A5A5);
        rd(32'h784, d); check("R2 bank15 window", d, 32'h0000_A5A5);
        rd(aof(14, 1), d); check("R2 neighbour bank untouched", d, 32'h0);
        rd(aof(1, 9), d); check("R2 clear reads zero", d, 32'h0);
        wr(aof(15, 1), 32'h0);

        // R5: input path on bank 1 pin 4
        wr(aof(1, 10), 32'h10);
        wr(aof(1, 1), 32'h10);
        pad_in[20] = 1'b1;
        tick(3);
        rd(aof(1, 0), d); check("R5 input read enabled", d, 32'h10);
        wr(aof(1, 10), 32'h0);
        rd(aof(1, 0), d); check("R5 input read disabled", d, 32'h0);
        wr(aof(1, 10), 32'h10);
        rd(aof(1, 0), d); check("R5 input read re-enabled", d, 32'h10);
        wr(aof(1, 1), 32'h0);
        rd(aof(1, 0), d); check("R4 masked input read", d, 32'h0);
        wr(aof(1, 1), 32'h10);

        // R6: rising edge with polarity 1
        wr(aof(1, 5), 32'h10);
        wr(aof(1, 6), 32'h10);
        pad_in[20] = 1'b0;
        tick(4);
        wr(aof(1, 9), 32'h10);
        rd(aof(1, 7), d); check("R10 raw cleared baseline", d, 32'h0);
        check("R9 irq low baseline", 32'(irq), 32'h0);
        pad_in[20] = 1'b1;
        tick(4);
        rd(aof(1, 7), d); check("R6 rising latched", d, 32'h10);
        rd(aof(1, 8), d); check("R9 masked status", d, 32'h10);
        check("R9 irq high", 32'(irq), 32'h1);
        wr(aof(1, 9), 32'h10);
        rd(aof(1, 7), d); check("R10 clear", d, 32'h0);
        check("R9 irq low after clear", 32'(irq), 32'h0);
        pad_in[20] = 1'b0;
        tick(4);
        rd(aof(1, 7), d); check("R6 falling ignored for pol 1", d, 32'h0);
        wr(aof(1, 5), 32'h0);
        pad_in[20] = 1'b1;
        tick(4);
        rd(aof(1, 7), d); check("R6 rising ignored for pol 0", d, 32'h0);
        pad_in[20] = 1'b0;
        tick(4);
        rd(aof(1, 7), d); check("R6 falling latched for pol 0", d, 32'h10);
        wr(aof(1, 9), 32'h10);

        // R7: any-edge
        wr(aof(1, 4), 32'h10);
        pad_in[20] = 1'b1;
        tick(4);
        rd(aof(1, 7), d); check("R7 rise latched", d, 32'h10);
        wr(aof(1, 9), 32'h10);
        pad_in[20] = 1'b0;
        tick(4);
        rd(aof(1, 7), d); check("R7 fall latched", d, 32'h10);
        wr(aof(1, 9), 32'h10);
        rd(aof(1, 7), d); check("R10 cleared after any-edge", d, 32'h0);

        // R8: level sensing
        wr(aof(1, 4), 32'h0);
        wr(aof(1, 3), 32'h10);
        wr(aof(1, 5), 32'h10);
        rd(aof(1, 7), d); check("R8 level high idle", d, 32'h0);
        pad_in[20] = 1'b1;
        tick(3);
        rd(aof(1, 7), d); check("R8 level high active", d, 32'h10);
        check("R9 irq on level", 32'(irq), 32'h1);
        wr(aof(1, 9), 32'h10);
        rd(aof(1, 7), d); check("R8 clear no effect", d, 32'h10);
        pad_in[20] = 1'b0;
        tick(3);
        rd(aof(1, 7), d); check("R8 level follows input", d, 32'h0);
        check("R9 irq drops", 32'(irq), 32'h0);
        wr(aof(1, 5), 32'h0);
        rd(aof(1, 7), d); check("R8 active low", d, 32'h10);
        wr(aof(1, 6), 32'h0);
        rd(aof(1, 8), d); check("R9 disabled masked", d, 32'h0);
        check("R9 irq disabled", 32'(irq), 32'h0);

        // R10: edge and clear collide
        wr(aof(1, 3), 32'h0);
        wr(aof(1, 5), 32'h10);
        wr(aof(1, 6), 32'h10);
        tick(3);
        wr(aof(1, 9), 32'h10);
        pad_in[20] = 1'b1;
        tick(2);
        wr(aof(1, 9), 32'h10);
        rd(aof(1, 7), d); check("R10 edge wins over clear", d, 32'h10);
        wr(aof(1, 9), 32'h10);
        rd(aof(1, 7), d); check("R10 later clear", d, 32'h0);

        // R9: interrupt from the last bank
        wr(aof(15, 10), 32'h1);
        wr(aof(15, 3), 32'h1);
        wr(aof(15, 5), 32'h1);
        wr(aof(15, 6), 32'h1);
        pad_in[240] = 1'b1;
        tick(3);
        rd(aof(15, 8), d); check("R9 bank15 masked", d, 32'h1);
        check("R9 irq from bank15", 32'(irq), 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule